// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Port

This block is a slave on a two-wire I2C bus that gives a host access to a small register file through an internal register pointer. The 7-bit device address is a fixed five-bit prefix followed by two bits taken from strap inputs, so up to four copies can share one bus. The block samples the bus lines through synchronizers and pulls SDA low through an output-enable. It does not stretch the clock.

A write transaction always carries the pointer as its first byte after the address. Any further bytes in the same transaction are written to the register that the pointer selects, and the pointer advances after each one. A read transaction returns register contents starting at the stored pointer and moves on to the next register each time the master acknowledges.

The pointer keeps its value across a stop condition and across a repeated start. A master can therefore send a write that carries only the pointer, stop, and then read from that register. The register file sits outside the block. Its address is the pointer itself, its read data is combinational, and a one-cycle write strobe carries each data byte.

Top module: `i2c_regport`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 10011 followed by `strap_i[1]`, `strap_i[0]`. The last bit of the address byte selects the direction: 0 means write and 1 means read.
- R2: When the address does not match, the slave does not acknowledge. It never drives SDA and issues no register write until the next start condition.
- R3: In a write transaction, the first byte after the address is acknowledged, and its low PTR_W bits become the pointer. These bits appear on `reg_addr`.
- R4: Each later byte of a write transaction is sampled MSB first and acknowledged. It is presented on `reg_wdata` with a one-cycle `reg_we` pulse while `reg_addr` holds the pointer, and the pointer then advances by one.
- R5: A pointer loaded by a write that is stopped right after the pointer byte stays unchanged, and the next read transaction starts at that register.
- R6: In a read transaction, the slave acknowledges its address and then shifts out the register at the pointer, MSB first. The pointer advances by one after every byte it sends.
- R7: After a master acknowledge, the slave sends the next register. After a master not-acknowledge, it leaves SDA released for the rest of the transaction. A stop condition always releases SDA.
- R8: The pointer wraps from 2^PTR_W-1 to 0, in both writes and reads.
- R9: A repeated start begins a new address phase without changing the pointer.
- R10: After reset, SDA is released, `reg_we` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | PTR_W | Register file address (the pointer) |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
Write transactions are tried with a pointer byte alone, with a pointer followed by several data bytes, and with a pointer set to the top register. These separate loading the pointer from writing data, and show where the pointer wraps. Reads follow a stopped write and a repeated start, with chains of master acknowledges that end in a not-acknowledge. These distinguish whether the pointer is kept, how it advances, and the release of SDA at the end. Addresses that differ only in the strap bits, or only in the fixed prefix, check that an unselected slave stays silent and writes nothing.

// File: rtl/i2c_regport_pkg.sv
// Package: shared constants and state encoding of the I2C register port.
package i2c_regport_pkg;
    localparam logic [4:0] DEV_PREFIX = 5'b10011;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,  // not selected, waiting for a start condition
        ST_ADDR,  // shifting in the address byte
        ST_AACK,  // driving the acknowledge of the address
        ST_RX,    // shifting in a pointer or data byte
        ST_RACK,  // driving the acknowledge of a received byte
        ST_TX,    // shifting out a register byte
        ST_MACK   // sampling the master's acknowledge
    } bus_state_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
// Module: i2c_bus_sampler
// Synchronizes SCL and SDA to clk and derives the SCL edge pulses and the
// start and stop conditions (an SDA edge while SCL is high).
// Assumes both lines are slow compared to clk and that the master never
// changes SDA in the same clk cycle as an SCL edge.
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // Synchronizer chains; reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode from the synchronized levels.
    always_comb begin
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_pipe[SYNC_STAGES-1] & ~scl_q;
        scl_fall  = ~scl_pipe[SYNC_STAGES-1] & scl_q;
        start_det = scl_pipe[SYNC_STAGES-1] & scl_q & sda_q & ~sda_s;
        stop_det  = scl_pipe[SYNC_STAGES-1] & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_ptr_reg.sv
// Module: i2c_ptr_reg
// Holds the register pointer. A load has priority over an increment, and
// the increment wraps at the top of the PTR_W-bit space.
// Assumes load and inc are single-cycle strobes.
module i2c_ptr_reg #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    // Pointer update: load, increment with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end

    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && ptr == {PTR_W{1'b1}}) |=> (ptr == '0));
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !inc) |=> $stable(ptr));
endmodule

// File: rtl/i2c_slave_engine.sv
// Module: i2c_slave_engine
// Byte-level slave protocol: address match, acknowledge, pointer byte,
// data writes and sequential reads. Samples SDA on SCL rise and changes
// its SDA drive on SCL fall.
// Assumes reg_rdata is valid for the current pointer in the same cycle.
module i2c_slave_engine
    import i2c_regport_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap_i,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_val,
    output logic              ptr_inc
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw, got_ptr, macked;
    logic              byte_end, addr_hit;

    // Byte boundary strobe and address comparison.
    always_comb begin
        byte_end = scl_fall && (bit_cnt == LAST_BIT);
        addr_hit = (shreg[7:1] == {DEV_PREFIX, strap_i});
    end

    // Protocol state machine with bit counter, shifter and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            rw        <= 1'b0;
            got_ptr   <= 1'b0;
            macked    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_AACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (got_ptr) begin
                                    reg_we    <= 1'b1;
                                    reg_wdata <= shreg;
                                end
                                got_ptr <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_RACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                shreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                got_ptr <= 1'b0;
                                state   <= ST_RX;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            macked <= ~sda_s;
                        end else if (scl_fall) begin
                            if (macked) begin
                                bit_cnt <= '0;
                                shreg   <= reg_rdata;
                                sda_oe  <= ~reg_rdata[BYTE_W-1];
                                state   <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pointer control: load from the first write byte, step after each data byte.
    always_comb begin
        ptr_load = (state == ST_RX) && byte_end && !got_ptr && !start_det && !stop_det;
        ptr_val  = shreg[PTR_W-1:0];
        ptr_inc  = reg_we || ((state == ST_TX) && byte_end && !start_det && !stop_det);
    end

    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    assert_no_ack_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_end && !addr_hit && !start_det && !stop_det)
            |=> (!sda_oe && state == ST_IDLE));
    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_det) |=> (!sda_oe && !reg_we));
endmodule

// File: rtl/i2c_regport.sv
// Module: i2c_regport (top)
// I2C slave register port: synchronizer/condition detector, protocol
// engine and register pointer. The pointer addresses the external file.
// Assumes an external pull-up on SDA and SCL and a clock-stretch-free master.
module i2c_regport #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       strap_i,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_load, ptr_inc;
    logic [PTR_W-1:0] ptr_val;

    i2c_bus_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_slave_engine #(.PTR_W(PTR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap_i(strap_i), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .ptr_inc(ptr_inc)
    );

    i2c_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
        .inc(ptr_inc), .ptr(reg_addr)
    );

    assert_start_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> $stable(reg_addr));
endmodule

// File: tb/tb_i2c_regport.sv
`timescale 1ns/1ps
// Directed bench: a bus master model, a register file model and one task per scenario.
module tb_i2c_regport;
    localparam int PTR_W = 4;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_oe, reg_we;
    logic [PTR_W-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [1<<PTR_W];
    logic sda_line;
    int total = 0, bad = 0, we_count = 0, oe_count = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regport #(.PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Register file model and activity counters.
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count++;
        end
        if (sda_oe) oe_count++;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        seen = sda_line; wq(Q);
        scl_m = 1'b0; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(give_ack ? 1'b0 : 1'b1, s);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] st, input bit rd);
        return {5'b10011, st, rd};
    endfunction

    task automatic t_reset();
        check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
        check(reg_we == 1'b0, "R10 no write", reg_we, 0);
        check(reg_addr == 0, "R10 pointer zero", reg_addr, 0);
    endtask

    task automatic t_write_burst();
        bit ack;
        bus_start();
        send_byte(addr_byte(2'b10, 0), ack);
        check(ack, "R1 write address ack", ack, 1);
        send_byte(8'h03, ack);
        check(ack, "R3 pointer ack", ack, 1);
        check(reg_addr == 3, "R3 pointer loaded", reg_addr, 3);
        send_byte(8'hA5, ack);
        check(ack, "R4 data ack", ack, 1);
        send_byte(8'h3C, ack);
        bus_stop();
        check(mem[3] == 8'hA5, "R4 first data byte", mem[3], 8'hA5);
        check(mem[4] == 8'h3C, "R4 second data byte", mem[4], 8'h3C);
        check(reg_addr == 5, "R4 pointer advanced", reg_addr, 5);
    endtask

    task automatic t_abort_then_read();
        bit ack;
        logic [7:0] v;
        int wc;
        wc = we_count;
        bus_start();
        send_byte(addr_byte(2'b10, 0), ack);
        send_byte(8'h07, ack);
        bus_stop();
        check(reg_addr == 7 && we_count == wc, "R5 pointer kept, no write", reg_addr, 7);
        bus_start();
        send_byte(addr_byte(2'b10, 1), ack);
        check(ack, "R1 read address ack", ack, 1);
        read_byte(1, v);
        check(v == mem[7], "R5 read starts at stored pointer", v, mem[7]);
        read_byte(1, v);
        check(v == mem[8], "R7 ack gives next register", v, mem[8]);
        read_byte(0, v);
        check(v == mem[9], "R6 third sequential byte", v, mem[9]);
        oe_count = 0;
        read_byte(0, v);
        check(oe_count == 0 && v == 8'hFF, "R7 released after nack", oe_count, 0);
        bus_stop();
        check(reg_addr == 10, "R6 pointer after three reads", reg_addr, 10);
    endtask

    task automatic t_wrap();
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte(addr_byte(2'b10, 0), ack);
        send_byte(8'h0F, ack);
        send_byte(8'h99, ack);
        send_byte(8'h42, ack);
        bus_stop();
        check(mem[15] == 8'h99 && mem[0] == 8'h42, "R8 write wraps", mem[0], 8'h42);
        check(reg_addr == 1, "R8 pointer after write wrap", reg_addr, 1);
        bus_start();
        send_byte(addr_byte(2'b10, 0), ack);
        send_byte(8'h0E, ack);
        bus_stop();
        bus_start();
        send_byte(addr_byte(2'b10, 1), ack);
        read_byte(1, v);
        check(v == mem[14], "R6 read at 14", v, mem[14]);
        read_byte(1, v);
        check(v == 8'h99, "R8 read at 15", v, 8'h99);
        read_byte(0, v);
        check(v == 8'h42, "R8 read wraps to 0", v, 8'h42);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit ack;
        int wc;
        logic [PTR_W-1:0] pa;
        pa = reg_addr;
        wc = we_count;
        oe_count = 0;
        bus_start();
        send_byte(addr_byte(2'b01, 0), ack);
        check(!ack, "R2 strap mismatch no ack", ack, 0);
        send_byte(8'h02, ack);
        send_byte(8'h55, ack);
        bus_stop();
        bus_start();
        send_byte(8'b1010_1100, ack);
        check(!ack, "R2 prefix mismatch no ack", ack, 0);
        send_byte(8'h05, ack);
        bus_stop();
        check(oe_count == 0, "R2 SDA never driven", oe_count, 0);
        check(we_count == wc && reg_addr == pa, "R2 no write, pointer kept", reg_addr, pa);
        strap = 2'b01;
        bus_start();
        send_byte(addr_byte(2'b01, 0), ack);
        check(ack, "R1 new strap value matches", ack, 1);
        bus_stop();
        strap = 2'b10;
    endtask

    task automatic t_repeated_start();
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte(addr_byte(2'b10, 0), ack);
        send_byte(8'h09, ack);
        bus_start();
        check(reg_addr == 9, "R9 pointer through repeated start", reg_addr, 9);
        send_byte(addr_byte(2'b10, 1), ack);
        check(ack, "R9 address after repeated start", ack, 1);
        read_byte(0, v);
        check(v == mem[9], "R9 read after repeated start", v, mem[9]);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < (1 << PTR_W); i++) mem[i] = 8'(i * 37 + 5);
        wq(4);
        t_reset();
        rst_n = 1'b1;
        wq(4);
        t_reset();
        t_write_burst();
        t_abort_then_read();
        t_wrap();
        t_mismatch();
        t_repeated_start();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule